// File: doc/BRIEF.md
# Lockable Cache Replacement Controller

This block keeps the tag, valid and lock state of a set-associative instruction cache and decides which way receives a new line. A requester issues one command at a time: a fill for a missed address, a lock for a line that must stay resident, or a global unlock. A fill or lock that misses fetches the line through a request/acknowledge memory port and then writes its tag. A separate lookup port reports hit and way for any address combinationally. The data array, the memory itself and the decode of the software command are outside the block.

Each set has its own round-robin victim pointer. The victim search starts at that pointer and passes over any way whose lock bit is set. Software locks a region by issuing one lock command per 32-byte line. A later global unlock clears every lock bit in one step. The lines stay valid and simply return to the replacement rotation. A set whose ways are all locked refuses a fill with an error flag.

The controller has three states. `ST_IDLE` accepts a command. Its transition to `ST_FETCH` is taken by a fill or lock that misses while an unlocked way exists. Its transition to `ST_RESP` is taken by every other command: a hit, an all-locked error, an unlock or a reserved code. `ST_FETCH` waits for the memory acknowledge, then writes the line and goes to `ST_RESP`. `ST_RESP` raises the acknowledge for one cycle and always returns to `ST_IDLE`.

Top module: `icache_lock_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), every line is invalid and unlocked and every set pointer is 0. The lookup port misses, `cmd_ready` is 1, and `cmd_ack` and `mem_req` are 0.
- R2: With default parameters, an address splits into line offset [4:0], set index [9:5] and tag [31:10]. The offset bits never affect any result. `lk_hit`/`lk_way` report combinationally whether a valid way of the set holds the tag. `lk_way` is 0 on a miss.
- R3: A fill (`cmd_op` 0) that misses with an unlocked way available holds `mem_req` high, with `mem_addr` equal to the command address with bits [4:0] cleared, until the cycle `mem_ack` is sampled high. At that edge the line becomes valid. `cmd_ack` is high in the next cycle with `cmd_hit` 0, `cmd_err` 0 and `cmd_way` set to the filled way.
- R4: A fill that hits makes no memory request and changes no state. `cmd_ack` follows in the cycle after acceptance, with `cmd_hit` 1 and `cmd_way` set to the hitting way.
- R5: The victim is the first unlocked way found by searching from the set pointer upward and wrapping. After an allocation into way v, the pointer becomes (v+1) mod WAYS, so a fresh set fills ways 0, 1, 2, 3 and then 0 again.
- R6: A locked way is never chosen as a victim, and its line keeps hitting across later fills to its set.
- R7: A fill or lock that misses in a set whose ways are all locked makes no memory request and replaces nothing. `cmd_ack` follows in the cycle after acceptance, with `cmd_err` 1, `cmd_hit` 0 and `cmd_way` 0.
- R8: A lock (`cmd_op` 1) that hits sets that way's lock bit without a refill. `cmd_ack` follows in the next cycle with `cmd_hit` 1 and `cmd_way` set to that way.
- R9: A lock that misses allocates a victim exactly as a fill does (R3, R5) and leaves the new line locked.
- R10: A global unlock (`cmd_op` 2) clears every lock bit in the cache at once. All lines stay valid and keep hitting, and the unlocked ways become victims again. It is acknowledged in the cycle after acceptance with `cmd_hit`, `cmd_err` and `cmd_way` all 0.
- R11: The reserved code (`cmd_op` 3) is acknowledged in the cycle after acceptance with all flags 0. It changes no tag, valid, lock or pointer state.
- R12: `cmd_ready` is high only in `ST_IDLE`, and `cmd_valid` is ignored when `cmd_ready` is low. `cmd_ack` lasts exactly one cycle and is followed by `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | ADDR_W | Address for the combinational lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Way that hit, 0 on a miss |
| cmd_valid | input | 1 | Command present, taken when `cmd_ready` is high |
| cmd_op | input | 2 | 0 fill, 1 lock, 2 global unlock, 3 reserved |
| cmd_addr | input | ADDR_W | Line address of a fill or lock |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| cmd_ack | output | 1 | One-cycle completion pulse |
| cmd_hit | output | 1 | Command address was already resident |
| cmd_err | output | 1 | Miss refused because every way of the set is locked |
| cmd_way | output | WAY_W | Way hit or filled |
| mem_req | output | 1 | Line fetch request |
| mem_addr | output | ADDR_W | Line-aligned fetch address |
| mem_ack | input | 1 | Fetch complete |

## Verification
A wrong lock bit or pointer shows no symptom until a later fill lands in that set. It then appears as a wrong `cmd_way` in the acknowledge of that fill, or as a lookup miss on a line that should have been protected. The bench therefore checks every acknowledge against a reference model and sweeps lookups after each command. A lost unlock appears at the first fill into a fully locked set, as a spurious `cmd_err`. A broken handshake is visible within one cycle as a repeated acknowledge, a dropped request or a moving fetch address.

// File: rtl/icl_pkg.sv
package icl_pkg;
    typedef enum logic [1:0] {
        OP_FILL       = 2'd0,
        OP_LOCK       = 2'd1,
        OP_UNLOCK_ALL = 2'd2,
        OP_RSVD       = 2'd3
    } icl_op_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } icl_state_t;
endpackage

// File: rtl/icl_way_match.sv
module icl_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           way
);
    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && valid[w] && (tags[w] == tag)) begin
                hit = 1'b1;
                way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/icl_victim_pick.sv
module icl_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  locked,
    input  logic [WAY_W-1:0] ptr,
    output logic             found,
    output logic [WAY_W-1:0] way
);
    int cand;

    always_comb begin
        found = 1'b0;
        way   = '0;
        cand  = 0;
        for (int k = 0; k < WAYS; k++) begin
            cand = (int'(ptr) + k) % WAYS;
            if (!found && !locked[cand]) begin
                found = 1'b1;
                way   = WAY_W'(cand);
            end
        end
    end
endmodule

// File: rtl/icl_tag_store.sv
module icl_tag_store #(
    parameter int SETS  = 32,
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    parameter int IDX_W = 5,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    output logic             a_hit,
    output logic [WAY_W-1:0] a_way,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    output logic             b_hit,
    output logic [WAY_W-1:0] b_way,
    output logic [WAYS-1:0]  b_lock,
    output logic [WAY_W-1:0] b_ptr,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [WAY_W-1:0] alloc_way,
    input  logic             alloc_lock,
    input  logic             lock_en,
    input  logic [IDX_W-1:0] lock_idx,
    input  logic [WAY_W-1:0] lock_way,
    input  logic             unlock_all
);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0]            lock_q  [SETS];
    logic [WAY_W-1:0]           ptr_q   [SETS];

    icl_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match_a (
        .valid (valid_q[a_idx]),
        .tags  (tag_q[a_idx]),
        .tag   (a_tag),
        .hit   (a_hit),
        .way   (a_way)
    );

    icl_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match_b (
        .valid (valid_q[b_idx]),
        .tags  (tag_q[b_idx]),
        .tag   (b_tag),
        .hit   (b_hit),
        .way   (b_way)
    );

    assign b_lock = lock_q[b_idx];
    assign b_ptr  = ptr_q[b_idx];

    // Tags carry no reset: an invalid way never matches.
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            tag_q[alloc_idx][alloc_way] <= alloc_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lock_q[s]  <= '0;
                ptr_q[s]   <= '0;
            end
        end else begin
            if (unlock_all) begin
                for (int s = 0; s < SETS; s++) begin
                    lock_q[s] <= '0;
                end
            end
            if (lock_en) begin
                lock_q[lock_idx][lock_way] <= 1'b1;
            end
            if (alloc_en) begin
                valid_q[alloc_idx][alloc_way] <= 1'b1;
                lock_q[alloc_idx][alloc_way]  <= alloc_lock;
                ptr_q[alloc_idx] <= (alloc_way == LAST_WAY) ? '0 : alloc_way + 1'b1;
            end
        end
    end
endmodule

// File: rtl/icl_ctrl.sv
module icl_ctrl
    import icl_pkg::*;
#(
    parameter int LINE_W = 27,
    parameter int OFS_W  = 5,
    parameter int IDX_W  = 5,
    parameter int TAG_W  = 22,
    parameter int WAY_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic              look_hit,
    input  logic [WAY_W-1:0]  look_way,
    input  logic              vic_found,
    input  logic [WAY_W-1:0]  vic_way,
    input  logic              mem_ack,
    output logic              cmd_ready,
    output logic              cmd_ack,
    output logic              cmd_hit,
    output logic              cmd_err,
    output logic [WAY_W-1:0]  cmd_way,
    output logic              mem_req,
    output logic [LINE_W+OFS_W-1:0] mem_addr,
    output logic              alloc_en,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic [WAY_W-1:0]  alloc_way,
    output logic              alloc_lock,
    output logic              lock_en,
    output logic [IDX_W-1:0]  lock_idx,
    output logic [WAY_W-1:0]  lock_way,
    output logic              unlock_all
);
    icl_state_t        state_q, state_d;
    icl_op_t           op_in, op_q;
    logic [LINE_W-1:0] line_q;
    logic [WAY_W-1:0]  way_q;
    logic              hit_q, err_q;
    logic              accept, is_alloc_op;

    assign op_in       = icl_op_t'(cmd_op);
    assign accept      = (state_q == ST_IDLE) && cmd_valid;
    assign is_alloc_op = (op_in == OP_FILL) || (op_in == OP_LOCK);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (is_alloc_op && !look_hit && vic_found) state_d = ST_FETCH;
                    else                                     state_d = ST_RESP;
                end
            end
            ST_FETCH: if (mem_ack) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Command capture at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_FILL;
            line_q <= '0;
            way_q  <= '0;
            hit_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (accept) begin
            op_q   <= op_in;
            line_q <= cmd_line;
            hit_q  <= is_alloc_op && look_hit;
            err_q  <= is_alloc_op && !look_hit && !vic_found;
            if (is_alloc_op && look_hit)       way_q <= look_way;
            else if (is_alloc_op && vic_found) way_q <= vic_way;
            else                               way_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        cmd_ack    = (state_q == ST_RESP);
        cmd_hit    = cmd_ack && hit_q;
        cmd_err    = cmd_ack && err_q;
        cmd_way    = cmd_ack ? way_q : '0;
        mem_req    = (state_q == ST_FETCH);
        mem_addr   = {line_q, {OFS_W{1'b0}}};
        alloc_en   = mem_req && mem_ack;
        alloc_idx  = line_q[IDX_W-1:0];
        alloc_tag  = line_q[LINE_W-1:IDX_W];
        alloc_way  = way_q;
        alloc_lock = (op_q == OP_LOCK);
        lock_en    = accept && (op_in == OP_LOCK) && look_hit;
        lock_idx   = cmd_line[IDX_W-1:0];
        lock_way   = look_way;
        unlock_all = accept && (op_in == OP_UNLOCK_ALL);
    end
endmodule

// File: rtl/icache_lock_ctrl.sv
module icache_lock_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 32,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 32,
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              cmd_ack,
    output logic              cmd_hit,
    output logic              cmd_err,
    output logic [WAY_W-1:0]  cmd_way,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int LINE_W = ADDR_W - OFS_W;
    localparam int TAG_W  = LINE_W - IDX_W;

    logic [LINE_W-1:0] cmd_line;
    logic [OFS_W-1:0]  unused_ofs;
    logic              look_hit, vic_found;
    logic [WAY_W-1:0]  look_way, vic_way, set_ptr;
    logic [WAYS-1:0]   set_lock;
    logic              alloc_en, alloc_lock, lock_en, unlock_all;
    logic [IDX_W-1:0]  alloc_idx, lock_idx;
    logic [TAG_W-1:0]  alloc_tag;
    logic [WAY_W-1:0]  alloc_way, lock_way;

    assign cmd_line   = cmd_addr[ADDR_W-1:OFS_W];
    assign unused_ofs = lk_addr[OFS_W-1:0] ^ cmd_addr[OFS_W-1:0];

    icl_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .a_idx      (lk_addr[OFS_W+IDX_W-1:OFS_W]),
        .a_tag      (lk_addr[ADDR_W-1:OFS_W+IDX_W]),
        .a_hit      (lk_hit),
        .a_way      (lk_way),
        .b_idx      (cmd_line[IDX_W-1:0]),
        .b_tag      (cmd_line[LINE_W-1:IDX_W]),
        .b_hit      (look_hit),
        .b_way      (look_way),
        .b_lock     (set_lock),
        .b_ptr      (set_ptr),
        .alloc_en   (alloc_en),
        .alloc_idx  (alloc_idx),
        .alloc_tag  (alloc_tag),
        .alloc_way  (alloc_way),
        .alloc_lock (alloc_lock),
        .lock_en    (lock_en),
        .lock_idx   (lock_idx),
        .lock_way   (lock_way),
        .unlock_all (unlock_all)
    );

    icl_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .locked (set_lock),
        .ptr    (set_ptr),
        .found  (vic_found),
        .way    (vic_way)
    );

    icl_ctrl #(
        .LINE_W(LINE_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_line   (cmd_line),
        .look_hit   (look_hit),
        .look_way   (look_way),
        .vic_found  (vic_found),
        .vic_way    (vic_way),
        .mem_ack    (mem_ack),
        .cmd_ready  (cmd_ready),
        .cmd_ack    (cmd_ack),
        .cmd_hit    (cmd_hit),
        .cmd_err    (cmd_err),
        .cmd_way    (cmd_way),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .alloc_en   (alloc_en),
        .alloc_idx  (alloc_idx),
        .alloc_tag  (alloc_tag),
        .alloc_way  (alloc_way),
        .alloc_lock (alloc_lock),
        .lock_en    (lock_en),
        .lock_idx   (lock_idx),
        .lock_way   (lock_way),
        .unlock_all (unlock_all)
    );
endmodule

// File: rtl/icache_lock_ctrl_chk.sv
module icache_lock_ctrl_chk #(
    parameter int ADDR_W     = 32,
    parameter int WAY_W      = 2,
    parameter int LINE_BYTES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_hit,
    input logic [WAY_W-1:0]  lk_way,
    input logic              cmd_ready,
    input logic              cmd_ack,
    input logic              cmd_hit,
    input logic              cmd_err,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    AST_RESET_READY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cmd_ready && !mem_req && !cmd_ack); // R1

    AST_LK_MISS_WAY_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> lk_way == '0); // R2

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[OFS_W-1:0] == '0); // R3

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R3

    AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        cmd_ack && cmd_hit |-> $past(cmd_ready)); // R4

    AST_ERR_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        cmd_ack && cmd_err |-> $past(cmd_ready) && !cmd_hit); // R7

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |=> !cmd_ack && cmd_ready); // R12

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !mem_req && !cmd_ack); // R12
endmodule

bind icache_lock_ctrl icache_lock_ctrl_chk #(
    .ADDR_W(ADDR_W), .WAY_W(WAY_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_hit    (lk_hit),
    .lk_way    (lk_way),
    .cmd_ready (cmd_ready),
    .cmd_ack   (cmd_ack),
    .cmd_hit   (cmd_hit),
    .cmd_err   (cmd_err),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack)
);

// File: tb/icache_lock_ctrl_bench.sv
module icache_lock_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int SETS   = 32;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int OFS_W  = 5;
    localparam int IDX_W  = 5;
    localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;
    localparam int WATCHDOG = 150000;

    localparam int OPC_FILL = 0;
    localparam int OPC_LOCK = 1;
    localparam int OPC_UNLK = 2;
    localparam int OPC_RSVD = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              cmd_ready, cmd_ack, cmd_hit, cmd_err;
    logic [WAY_W-1:0]  cmd_way;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    bit [TAG_W-1:0] m_tag [SETS][WAYS];
    bit             m_val [SETS][WAYS];
    bit             m_lck [SETS][WAYS];
    int             m_ptr [SETS];

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_lock_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(32)) u_icache_lock_ctrl (
        .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_way(lk_way),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_ready(cmd_ready), .cmd_ack(cmd_ack), .cmd_hit(cmd_hit), .cmd_err(cmd_err),
        .cmd_way(cmd_way), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack)
    );

    function automatic logic [ADDR_W-1:0] mk(int tag, int set, int ofs);
        return {TAG_W'(tag), IDX_W'(set), OFS_W'(ofs)};
    endfunction

    function automatic int m_find(int s, bit [TAG_W-1:0] t);
        for (int w = 0; w < WAYS; w++)
            if (m_val[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic int m_pick(int s);
        for (int k = 0; k < WAYS; k++)
            if (!m_lck[s][(m_ptr[s] + k) % WAYS]) return (m_ptr[s] + k) % WAYS;
        return -1;
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic lk_check(logic [ADDR_W-1:0] a, string rq);
        int s, w;
        s = int'(a[OFS_W+IDX_W-1:OFS_W]);
        w = m_find(s, a[ADDR_W-1:OFS_W+IDX_W]);
        lk_addr = a;
        #1;
        chk(lk_hit == (w >= 0), rq, "lk_hit", lk_hit, w >= 0);
        chk(lk_way == WAY_W'((w >= 0) ? w : 0), rq, "lk_way", lk_way, (w >= 0) ? w : 0);
    endtask

    task automatic run_cmd(int op, logic [ADDR_W-1:0] a, bit noisy, string rq);
        int  s, hw, vw, exp_way;
        bit  exp_hit, exp_err, exp_fetch, fetched, got;
        bit [TAG_W-1:0] t;
        s = int'(a[OFS_W+IDX_W-1:OFS_W]);
        t = a[ADDR_W-1:OFS_W+IDX_W];
        hw = m_find(s, t);
        vw = -1; exp_way = 0; exp_hit = 0; exp_err = 0; exp_fetch = 0;
        if (op == OPC_FILL || op == OPC_LOCK) begin
            if (hw >= 0) begin exp_hit = 1; exp_way = hw; end
            else begin
                vw = m_pick(s);
                if (vw < 0) exp_err = 1;
                else begin exp_fetch = 1; exp_way = vw; end
            end
        end
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R12", "ready before command", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        fetched = 0; got = 0;
        for (int cyc = 0; cyc < 60 && !got; cyc++) begin
            if (cmd_ack) begin
                got = 1;
                cmd_valid = 1'b0;
                chk(cmd_hit == exp_hit, rq, "cmd_hit", cmd_hit, exp_hit);
                chk(cmd_err == exp_err, rq, "cmd_err", cmd_err, exp_err);
                chk(cmd_way == WAY_W'(exp_way), rq, "cmd_way", cmd_way, exp_way);
                chk(fetched == exp_fetch, rq, "fetch made", fetched, exp_fetch);
            end else if (mem_req) begin
                fetched = 1;
                chk(mem_addr == {a[ADDR_W-1:OFS_W], 5'd0}, "R3", "mem_addr", mem_addr,
                    {a[ADDR_W-1:OFS_W], 5'd0});
                chk(cmd_ready == 1'b0, "R12", "ready during fetch", cmd_ready, 0);
                if (noisy) begin cmd_valid = 1'b1; cmd_op = 2'(OPC_UNLK); end
                if ($urandom_range(0, 2) == 0) mem_ack = 1'b1;
            end
            if (!got) begin
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
        chk(got, "R12", "ack seen", got, 1);
        @(negedge clk);
        chk(!cmd_ack && cmd_ready, "R12", "ack single cycle", cmd_ack, 0);
        if (op == OPC_LOCK && hw >= 0) m_lck[s][hw] = 1;
        if (exp_fetch) begin
            m_tag[s][vw] = t; m_val[s][vw] = 1; m_lck[s][vw] = (op == OPC_LOCK);
            m_ptr[s] = (vw + 1) % WAYS;
        end
        if (op == OPC_UNLK)
            for (int i = 0; i < SETS; i++)
                for (int j = 0; j < WAYS; j++) m_lck[i][j] = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < SETS; i++) begin
            m_ptr[i] = 0;
            for (int j = 0; j < WAYS; j++) begin m_val[i][j] = 0; m_lck[i][j] = 0; m_tag[i][j] = '0; end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
        chk(cmd_ack == 1'b0, "R1", "cmd_ack", cmd_ack, 0);
        chk(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
        lk_check(mk(0, 0, 0), "R1");
        lk_check(mk(5, 3, 0), "R1");

        // R3, R5 fresh set fills in order; offset bits ignored (R2)
        run_cmd(OPC_FILL, mk(1, 3, 7), 0, "R3");
        lk_check(mk(1, 3, 31), "R2");
        lk_check(mk(1, 4, 0), "R2");
        run_cmd(OPC_FILL, mk(2, 3, 0), 0, "R5");
        run_cmd(OPC_FILL, mk(3, 3, 1), 0, "R5");
        run_cmd(OPC_FILL, mk(4, 3, 2), 0, "R5");
        run_cmd(OPC_FILL, mk(5, 3, 3), 0, "R5");
        lk_check(mk(1, 3, 0), "R5");
        // R4 fill hit
        run_cmd(OPC_FILL, mk(2, 3, 9), 0, "R4");
        // R8 lock hit, then R6 skipping
        run_cmd(OPC_LOCK, mk(3, 3, 0), 0, "R8");
        for (int k = 6; k < 11; k++) run_cmd(OPC_FILL, mk(k, 3, 0), 0, "R6");
        lk_check(mk(3, 3, 4), "R6");
        // R9 lock misses fill set 7, then R7 refused
        for (int k = 1; k < 5; k++) run_cmd(OPC_LOCK, mk(k, 7, k), 0, "R9");
        run_cmd(OPC_FILL, mk(5, 7, 0), 0, "R7");
        run_cmd(OPC_LOCK, mk(6, 7, 0), 0, "R7");
        for (int k = 1; k < 6; k++) lk_check(mk(k, 7, 0), "R7");
        // R11 reserved code
        run_cmd(OPC_RSVD, mk(5, 7, 0), 0, "R11");
        lk_check(mk(5, 7, 0), "R11");
        run_cmd(OPC_FILL, mk(7, 7, 0), 0, "R11");
        // R10 unlock keeps lines resident
        run_cmd(OPC_UNLK, mk(0, 0, 0), 0, "R10");
        for (int k = 1; k < 5; k++) lk_check(mk(k, 7, 0), "R10");
        run_cmd(OPC_FILL, mk(5, 7, 0), 0, "R10");
        lk_check(mk(1, 7, 0), "R10");
        // R12 commands ignored while busy
        run_cmd(OPC_LOCK, mk(2, 9, 0), 0, "R9");
        run_cmd(OPC_FILL, mk(1, 9, 0), 1, "R12");
        for (int k = 3; k < 6; k++) run_cmd(OPC_FILL, mk(k, 9, 0), 0, "R12");
        lk_check(mk(2, 9, 0), "R12");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int r, op;
            r = int'($urandom_range(0, 19));
            op = (r < 10) ? OPC_FILL : (r < 17) ? OPC_LOCK : (r < 19) ? OPC_UNLK : OPC_RSVD;
            run_cmd(op, mk(int'($urandom_range(1, 6)), int'($urandom_range(0, 3)),
                           int'($urandom_range(0, 31))), 0, "R5");
            if (n % 10 == 0)
                for (int q = 0; q < 4; q++)
                    lk_check(mk(int'($urandom_range(1, 6)), int'($urandom_range(0, 3)),
                                int'($urandom_range(0, 31))), "R2");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule